// File: doc/BRIEF.md
# SEC-DED 32-bit Hamming Codec

This block protects a 39-bit memory word: 32 data bits and 7 check bits. It is purely combinational. On the write path it turns a data word into the check word that is stored alongside it. On the read path it takes the stored data and the stored check bits and does four things:

- It regenerates the check word from the stored data.
- It forms a 7-bit syndrome.
- It raises an active-low single-error flag and an active-low multiple-error flag.
- It returns the data word with any single data-bit error inverted back.

The syndrome uses inverted sense: "no error" is all ones, and every disagreeing check bit shows as a low bit. The low pattern of a single data-bit error equals that bit's column of the parity matrix. This lets the syndrome point at the failing storage bit. Three of the check bits use odd parity, so neither an all-zeros nor an all-ones stored word is a valid codeword. Both are therefore reported as errors.

The same instance serves both directions. `check_o` always carries the check word of `data_i`, so a writer uses `check_o` and ignores the flags. A reader presents the stored word and uses `data_o`, `syn_o` and the two flags.

Top module: `secded_codec`

## Requirements
- R1: check_o[r] is the parity of the 16 data bits whose matrix column has bit r set. For r = 0, 1, 2 the parity is inverted (XNOR, odd parity). For r = 3 to 6 it is plain XOR (even parity). Every matrix row holds exactly 16 ones.
- R2: The matrix columns, written as 7-bit masks (bit r = check bit r), for data bits 0 to 31 are: 4F 26 46 1A 25 2A 43 45 61 19 4A 07 32 52 0B 62 1C 31 5B 3D 2C 3B 4C 34 54 64 1F 38 67 79 58 75. Data word 0x00000001 gives check_o = 0x48.
- R3: syn_o is the bitwise XNOR of check_i with the check word regenerated from data_i. When syn_o is all ones, err_no and merr_no are both high and data_o equals data_i.
- R4: A single flipped data bit d drives low exactly the syn_o bits set in column d (3 or 5 bits). err_no goes low, merr_no stays high, and data_o has bit d inverted back. A flip of data bit 31 gives syn_o = 7'b0001010.
- R5: A single flipped check bit r drives only syn_o[r] low. err_no goes low, merr_no stays high, and data_o equals data_i.
- R6: Any two flipped bits among the 39 (data/data, check/check or data/check) give an even, nonzero number of low syndrome bits. Both flags go low and data_o equals data_i.
- R7: A syndrome with an odd number of low bits that matches no data column and is not a single check bit sets both flags low and leaves data_o equal to data_i.
- R8: A stored word of all zeros (data 0, check 0) and one of all ones (data FFFFFFFF, check 7F) both drive err_no low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Data word to encode, or stored data word to check |
| check_i | input | 7 | Stored check word |
| data_o | output | 32 | data_i with a located single data-bit error inverted |
| check_o | output | 7 | Check word generated from data_i |
| syn_o | output | 7 | Syndrome, all ones when no error, low bits mark disagreement |
| err_no | output | 1 | Low when any syndrome bit is low |
| merr_no | output | 1 | Low when the syndrome is not a no-error or single-error pattern |

## Verification
Several data words are driven with their correct check word. Against these sit all 39 single-bit flips and random two-bit flips over the full 39-bit word. Every one of the 128 check-bit flip masks is also applied, which covers the clean, single-check, double and odd-uncorrectable syndrome classes in one sweep. The sweep tells a correctable data-column match apart from an odd pattern that only looks like a single error. The all-zeros and all-ones words, and the named vectors for data bit 0 and data bit 31, pin the parity polarity and column order.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CHK_W    = 7;
  localparam int unsigned ODD_ROWS = 3;  // rows 0..ODD_ROWS-1 use inverted parity

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  chk_t;

  // Column d: which check rows include data bit d.
  function automatic chk_t col_of(input int unsigned d);
    chk_t c;
    case (d)
      0:  c = 7'h4F;  1:  c = 7'h26;  2:  c = 7'h46;  3:  c = 7'h1A;
      4:  c = 7'h25;  5:  c = 7'h2A;  6:  c = 7'h43;  7:  c = 7'h45;
      8:  c = 7'h61;  9:  c = 7'h19;  10: c = 7'h4A;  11: c = 7'h07;
      12: c = 7'h32;  13: c = 7'h52;  14: c = 7'h0B;  15: c = 7'h62;
      16: c = 7'h1C;  17: c = 7'h31;  18: c = 7'h5B;  19: c = 7'h3D;
      20: c = 7'h2C;  21: c = 7'h3B;  22: c = 7'h4C;  23: c = 7'h34;
      24: c = 7'h54;  25: c = 7'h64;  26: c = 7'h1F;  27: c = 7'h38;
      28: c = 7'h67;  29: c = 7'h79;  30: c = 7'h58;  31: c = 7'h75;
      default: c = '0;
    endcase
    return c;
  endfunction

  // Row r: data bits feeding check bit r.
  function automatic data_t row_of(input int unsigned r);
    data_t m;
    chk_t  c;
    m = '0;
    for (int unsigned d = 0; d < DATA_W; d++) begin
      c    = col_of(d);
      m[d] = c[r];
    end
    return m;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CHK_W,
  parameter int unsigned NO = ODD_ROWS
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] check_o
);
  for (genvar r = 0; r < CW; r++) begin : g_row
    localparam data_t ROW_MASK = row_of(r);
    logic par;
    assign par = ^(data_i & ROW_MASK);
    if (r < NO) begin : g_odd
      assign check_o[r] = ~par;
    end else begin : g_even
      assign check_o[r] = par;
    end
  end
endmodule

// File: rtl/secded_syn.sv
module secded_syn
  import secded_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CHK_W
) (
  input  logic [CW-1:0] stored_i,
  input  logic [CW-1:0] regen_i,
  output logic [CW-1:0] syn_o,
  output logic [DW-1:0] hit_o,
  output logic          err_no,
  output logic          merr_no
);
  logic [CW-1:0] low;
  logic          chk_single;
  logic          correctable;

  assign syn_o = ~(stored_i ^ regen_i);
  assign low   = ~syn_o;

  for (genvar d = 0; d < DW; d++) begin : g_col
    localparam chk_t COL = col_of(d);
    assign hit_o[d] = (low == COL);
  end

  assign chk_single  = $onehot(low);
  assign correctable = (|hit_o) | chk_single;
  assign err_no      = ~(|low);
  assign merr_no     = ~((|low) & ~correctable);
endmodule

// File: rtl/secded_fix.sv
module secded_fix #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] hit_i,
  output logic [DW-1:0] data_o
);
  assign data_o = data_i ^ hit_i;
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CHK_W
) (
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] check_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] check_o,
  output logic [CW-1:0] syn_o,
  output logic          err_no,
  output logic          merr_no
);
  logic [DW-1:0] hit;

  secded_enc #(.DW(DW), .CW(CW), .NO(ODD_ROWS)) u_enc (
    .data_i (data_i),
    .check_o(check_o)
  );

  secded_syn #(.DW(DW), .CW(CW)) u_syn (
    .stored_i(check_i),
    .regen_i (check_o),
    .syn_o   (syn_o),
    .hit_o   (hit),
    .err_no  (err_no),
    .merr_no (merr_no)
  );

  secded_fix #(.DW(DW)) u_fix (
    .data_i(data_i),
    .hit_i (hit),
    .data_o(data_o)
  );
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 7
) (
  input logic [DW-1:0] data_i,
  input logic [DW-1:0] data_o,
  input logic [CW-1:0] syn_o,
  input logic          err_no,
  input logic          merr_no
);
  always_comb begin
    // R3: clean syndrome keeps both flags high and data untouched
    a_r3_clean_pass: assert (!(&syn_o) || (err_no && merr_no && data_o == data_i))
      else $error("a_r3_clean_pass");
    // R3: err flag tracks any low syndrome bit
    a_r3_err_tracks_syn: assert (err_no == (&syn_o))
      else $error("a_r3_err_tracks_syn");
    // R4: at most one bit is ever corrected
    a_r4_one_fix: assert ($countones(data_o ^ data_i) <= 1)
      else $error("a_r4_one_fix");
    // R5: single low syndrome bit is a check-bit error, no data change
    a_r5_chk_single: assert (!($countones(~syn_o) == 1) || (!err_no && merr_no && data_o == data_i))
      else $error("a_r5_chk_single");
    // R6: even nonzero low count is a double error, uncorrected
    a_r6_double: assert (!($countones(~syn_o) != 0 && $countones(~syn_o) % 2 == 0)
                         || (!err_no && !merr_no && data_o == data_i))
      else $error("a_r6_double");
    // R7: multiple-error never coexists with a correction
    a_r7_no_fix_on_merr: assert (merr_no || (data_o == data_i && !err_no))
      else $error("a_r7_no_fix_on_merr");
  end
endmodule

bind secded_codec secded_codec_chk #(.DW(DW), .CW(CW)) u_chk (
  .data_i (data_i),
  .data_o (data_o),
  .syn_o  (syn_o),
  .err_no (err_no),
  .merr_no(merr_no)
);

// File: tb/sim_secded_codec.sv
module sim_secded_codec;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] data_i = '0;
  logic [6:0]  check_i = '0;
  logic [31:0] data_o;
  logic [6:0]  check_o, syn_o;
  logic        err_no, merr_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  secded_codec u0 (
    .data_i (data_i),
    .check_i(check_i),
    .data_o (data_o),
    .check_o(check_o),
    .syn_o  (syn_o),
    .err_no (err_no),
    .merr_no(merr_no)
  );

  // Column table from R2
  function automatic logic [6:0] ref_col(input int d);
    case (d)
      0: return 7'h4F;  1: return 7'h26;  2: return 7'h46;  3: return 7'h1A;
      4: return 7'h25;  5: return 7'h2A;  6: return 7'h43;  7: return 7'h45;
      8: return 7'h61;  9: return 7'h19;  10: return 7'h4A; 11: return 7'h07;
      12: return 7'h32; 13: return 7'h52; 14: return 7'h0B; 15: return 7'h62;
      16: return 7'h1C; 17: return 7'h31; 18: return 7'h5B; 19: return 7'h3D;
      20: return 7'h2C; 21: return 7'h3B; 22: return 7'h4C; 23: return 7'h34;
      24: return 7'h54; 25: return 7'h64; 26: return 7'h1F; 27: return 7'h38;
      28: return 7'h67; 29: return 7'h79; 30: return 7'h58; 31: return 7'h75;
      default: return 7'h00;
    endcase
  endfunction

  // R1 reference: parity per row, rows 0..2 inverted
  function automatic logic [6:0] ref_chk(input logic [31:0] d);
    logic [6:0] c;
    for (int r = 0; r < 7; r++) begin
      logic p;
      logic [6:0] col;
      p = 1'b0;
      for (int k = 0; k < 32; k++) begin
        col = ref_col(k);
        if (col[r]) p = p ^ d[k];
      end
      c[r] = (r < 3) ? ~p : p;
    end
    return c;
  endfunction

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] d, input logic [6:0] c);
    @(posedge clk);
    #1;
    data_i  = d;
    check_i = c;
    @(negedge clk);
  endtask

  // Drive one word and compare every output with the reference model.
  task automatic apply(input logic [31:0] d, input logic [6:0] c, input string tag);
    logic [6:0]  gen, low;
    logic [31:0] exp_d;
    logic        exp_err, exp_merr;
    int          hit;
    drive(d, c);
    gen = ref_chk(d);
    low = gen ^ c;
    hit = -1;
    for (int k = 0; k < 32; k++) if (ref_col(k) == low) hit = k;
    exp_d = d;
    if (hit >= 0) exp_d[hit] = ~exp_d[hit];
    exp_err  = (low == 7'h00);
    exp_merr = !(low != 7'h00 && hit < 0 && $countones(low) != 1);
    checks++;
    if (data_o !== exp_d || check_o !== gen || syn_o !== ~low ||
        err_no !== exp_err || merr_no !== exp_merr) begin
      errors++;
      $display("FAIL %s in=%h/%h actual d=%h c=%h s=%h e=%b m=%b expected d=%h c=%h s=%h e=%b m=%b",
               tag, d, c, data_o, check_o, syn_o, err_no, merr_no,
               exp_d, gen, ~low, exp_err, exp_merr);
    end
  endtask

  function automatic string tag_for_mask(input logic [6:0] m);
    int w;
    w = $countones(m);
    if (w == 0) return "R3";
    if (w == 1) return "R5";
    if (w % 2 == 0) return "R6";
    for (int k = 0; k < 32; k++) if (ref_col(k) == m) return "R4";
    return "R7";
  endfunction

  initial begin
    logic [31:0] words [4];
    words[0] = 32'h0000_0000;
    words[1] = 32'hFFFF_FFFF;
    words[2] = 32'hA5C3_0F96;
    words[3] = 32'h1234_5678;

    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // Reset/idle state: clean codeword for zero data (R3)
    apply(32'h0, ref_chk(32'h0), "R3");
    expect_eq("R3 idle err_no", {31'h0, err_no}, 32'h1);

    // R2: named vector
    drive(32'h0000_0001, 7'h48);
    expect_eq("R2 check_o for 0x1", {25'h0, check_o}, 32'h48);
    expect_eq("R2 syn_o clean", {25'h0, syn_o}, 32'h7F);

    // R1: walking ones and patterns with correct check words
    for (int k = 0; k < 32; k++) apply(32'h1 << k, ref_chk(32'h1 << k), "R1");
    for (int i = 0; i < 4; i++) apply(words[i], ref_chk(words[i]), "R1");
    for (int i = 0; i < 40; i++) begin
      logic [31:0] v;
      v = $urandom;
      apply(v, ref_chk(v), "R1");
    end

    // R4: every single data-bit flip; R5: every single check-bit flip
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 32; k++)
        apply(words[i] ^ (32'h1 << k), ref_chk(words[i]), "R4");
      for (int r = 0; r < 7; r++)
        apply(words[i], ref_chk(words[i]) ^ (7'h1 << r), "R5");
    end

    // R4: bit 31 named syndrome and correction
    drive(32'h8000_0000 ^ words[3], ref_chk(words[3]));
    expect_eq("R4 syn for bit31", {25'h0, syn_o}, 32'h0A);
    expect_eq("R4 corrected bit31", data_o, words[3]);
    expect_eq("R4 flags bit31", {30'h0, err_no, merr_no}, 32'h1);

    // R3/R5/R6/R7: all 128 check-flip masks on each word
    for (int i = 0; i < 4; i++)
      for (int m = 0; m < 128; m++)
        apply(words[i], ref_chk(words[i]) ^ 7'(m), tag_for_mask(7'(m)));

    // R7: an odd syndrome that matches no column
    drive(words[2], ref_chk(words[2]) ^ 7'h0E);
    expect_eq("R7 odd unmatched flags", {30'h0, err_no, merr_no}, 32'h0);
    expect_eq("R7 odd unmatched data", data_o, words[2]);

    // R6: random double flips over all 39 positions
    for (int n = 0; n < 400; n++) begin
      int a, b;
      logic [31:0] d;
      logic [6:0]  c;
      a = $urandom_range(38, 0);
      b = $urandom_range(38, 0);
      if (a == b) b = (a + 1) % 39;
      d = $urandom;
      c = ref_chk(d);
      if (a < 32) d[a] = ~d[a]; else c[a-32] = ~c[a-32];
      if (b < 32) d[b] = ~d[b]; else c[b-32] = ~c[b-32];
      apply(d, c, "R6");
      expect_eq("R6 double flags", {30'h0, err_no, merr_no}, 32'h0);
    end

    // R8: gross all-zeros and all-ones words
    drive(32'h0000_0000, 7'h00);
    expect_eq("R8 all zeros err_no", {31'h0, err_no}, 32'h0);
    drive(32'hFFFF_FFFF, 7'h7F);
    expect_eq("R8 all ones err_no", {31'h0, err_no}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule